// File: doc/BRIEF.md
# Transmit Bit Retiming Latch

This block lets a host controller feed transmit data to a 1200 bit/s FSK modulator one bit at a time, so no UART is needed. It holds two one-bit stages. The first stage is loaded by the host's strobe. The second stage updates on an internal baud tick, which is made by dividing the system clock (3.579545 MHz by default, giving about 1200 Hz). At every tick the block looks at the level of the host strobe, and that level decides what drives the modulator until the next tick. If the strobe is low, the modulator takes the retimed bit and the block asks for the next bit by pulling an active-low ready line. If the strobe is high, the modulator follows the raw transmit pin.

The host keeps the strobe low until ready falls. It then puts the next bit on the data pin and pulses the strobe high. The rising edge latches the bit and the high level drops the request. A host that never wants retiming holds the strobe high; the modulator then always sees the raw pin. Retiming works only in the high-rate transmit mode. In every other mode the data passes straight through and no request is raised.

Top module: `tx_bit_retimer`

## Requirements
- R1: While reset is active, `rdy_no` is 1 and `mod_data_o` equals `txd_i`. Both stages reset to mark (1).
- R2: A baud tick occurs once every `TICK_DIV` clock cycles. Two requests in a row are exactly `TICK_DIV` cycles apart.
- R3: `strobe_i` and `txd_i` each pass through a two-flop synchroniser. On the third rising clock edge after `strobe_i` rises, the first stage captures the synchronised `txd_i`.
- R4: At a tick where `mode_i == 2'b01` and the synchronised strobe is low, the following happen on that same clock edge:
  - the second stage loads the first stage;
  - `mod_data_o` switches to the second stage;
  - `rdy_no` goes low.
- R5: At a tick where the synchronised strobe is high, `mod_data_o` follows `txd_i` combinationally. The data choice made at a tick holds until the next tick.
- R6: When the synchronised strobe is high, `rdy_no` returns to 1 at the next clock edge. `rdy_no` never falls except on a tick.
- R7: When `mode_i != 2'b01`, the following hold from the next clock edge: `rdy_no` is 1, `mod_data_o` follows `txd_i`, and no request is raised.
- R8: While retimed data is selected, changes on `txd_i` have no effect on `mod_data_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (nominally 3.579545 MHz) |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode; 2'b01 is high-rate transmit |
| strobe_i | input | 1 | Host strobe: its rising edge latches data, its high level acknowledges a request |
| txd_i | input | 1 | Transmit data from the host |
| mod_data_o | output | 1 | Data bit driven to the FSK modulator |
| rdy_no | output | 1 | Active-low request for the next bit |

## Verification
An error in the tick counter shows at the ports as a ready fall one cycle early or late, within the first two baud periods after reset. The bench pins down the exact cycle of each fall. A fault in the first stage or in the synchroniser shows as the wrong retimed bit on `mod_data_o`, exactly one tick after the strobe pulse. A stuck selection flag shows one of two ways:
- raw `txd_i` toggles reaching the modulator while retiming is active, or
- the modulator staying frozen after the host switches to pass-through.

Both show up at the first toggle after the next tick.

// File: rtl/tx_bit_retimer.sv
module tx_bit_retimer #(
  parameter int unsigned TICK_DIV    = 2983,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       strobe_i,
  input  logic       txd_i,
  output logic       mod_data_o,
  output logic       rdy_no
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  localparam logic [1:0] MODE_TX_HI = 2'b01;

  logic [CW-1:0]          cnt_q;
  logic [SYNC_STAGES-1:0] strb_sr, txd_sr;
  logic                   strb_d, hold_q, bit_q, sel_q;

  wire tick     = (cnt_q == LAST);
  wire strb_s   = strb_sr[SYNC_STAGES-1];
  wire txd_s    = txd_sr[SYNC_STAGES-1];
  wire strb_up  = strb_s & ~strb_d;
  wire retime_m = (mode_i == MODE_TX_HI);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      strb_sr <= '0;
      txd_sr  <= '1;
      strb_d  <= 1'b0;
    end else begin
      cnt_q   <= tick ? '0 : cnt_q + 1'b1;
      strb_sr <= {strb_sr[SYNC_STAGES-2:0], strobe_i};
      txd_sr  <= {txd_sr[SYNC_STAGES-2:0], txd_i};
      strb_d  <= strb_s;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      bit_q  <= 1'b1;
      sel_q  <= 1'b0;
      rdy_no <= 1'b1;
    end else begin
      if (strb_up) hold_q <= txd_s;
      if (tick) bit_q <= hold_q;
      if (!retime_m) begin
        sel_q  <= 1'b0;
        rdy_no <= 1'b1;
      end else if (tick) begin
        sel_q  <= ~strb_s;
        rdy_no <= strb_s;
      end else if (strb_s) begin
        rdy_no <= 1'b1;
      end
    end
  end

  assign mod_data_o = sel_q ? bit_q : txd_i;
endmodule

module tx_bit_retimer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       tick,
  input logic       strb_s,
  input logic       hold_q,
  input logic       bit_q,
  input logic       sel_q,
  input logic       rdy_no
);
  a_r2_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
  a_r4_stage_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (bit_q == $past(hold_q)));
  a_r5_sel_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && mode_i == 2'b01) |=> $stable(sel_q));
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_s |=> rdy_no);
  a_r6_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> $past(tick));
  a_r7_other_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b01) |=> (rdy_no && !sel_q));
endmodule

bind tx_bit_retimer tx_bit_retimer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .tick(tick),
  .strb_s(strb_s), .hold_q(hold_q), .bit_q(bit_q), .sel_q(sel_q),
  .rdy_no(rdy_no)
);

// File: tb/tx_bit_retimer_tb.sv
module tx_bit_retimer_tb;
  localparam int DIV = 16;
  localparam int NV  = 8;
  // each entry: {retimed bit, raw txd value applied afterwards}
  localparam logic [1:0] VEC [NV] = '{2'b01, 2'b10, 2'b00, 2'b11,
                                      2'b01, 2'b01, 2'b10, 2'b00};

  logic clk = 0, rst_n = 0, strobe = 0, txd = 0;
  logic [1:0] mode = 2'b01;
  logic mod_data, rdy_n;
  int runs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tx_bit_retimer #(.TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .strobe_i(strobe),
    .txd_i(txd), .mod_data_o(mod_data), .rdy_no(rdy_n));

  task automatic chk(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_rdy(output bit ok);
    ok = 0;
    for (int i = 0; i < 4*DIV; i++) begin
      @(negedge clk);
      if (rdy_n == 1'b0) begin ok = 1; break; end
    end
  endtask

  task automatic send_bit(input logic b, input logic raw);
    txd = b; strobe = 1;
    repeat (5) @(negedge clk);
    chk("R6 release", rdy_n, 1'b1);
    strobe = 0; txd = raw;
    repeat (DIV-6) @(negedge clk);
    chk("R2 no early tick", rdy_n, 1'b1);
    @(negedge clk);
    chk("R4 request", rdy_n, 1'b0);
    chk("R3 retimed bit", mod_data, b);
    txd = ~raw; #1;
    chk("R8 raw ignored", mod_data, b);
  endtask

  initial begin
    bit ok;
    int lows;
    repeat (3) @(negedge clk);
    chk("R1 rdy reset", rdy_n, 1'b1);
    chk("R1 raw in reset", mod_data, 1'b0);
    rst_n = 1;
    wait_rdy(ok);
    chk("R4 first request", ok, 1'b1);
    chk("R1 mark reset contents", mod_data, 1'b1);
    for (int v = 0; v < NV; v++) send_bit(VEC[v][1], VEC[v][0]);

    strobe = 1; txd = 0;
    repeat (DIV) @(negedge clk);
    chk("R6 rdy high", rdy_n, 1'b1);
    txd = 1; #1;
    chk("R5 raw follow 1", mod_data, 1'b1);
    txd = 0; #1;
    chk("R5 raw follow 0", mod_data, 1'b0);

    strobe = 0;
    wait_rdy(ok);
    chk("R4 request after raw", ok, 1'b1);
    txd = 1; #1;
    chk("R3 latched 0", mod_data, 1'b0);

    mode = 2'b10;
    @(negedge clk);
    chk("R7 rdy released", rdy_n, 1'b1);
    chk("R7 raw 1", mod_data, 1'b1);
    txd = 0; #1;
    chk("R7 raw 0", mod_data, 1'b0);
    lows = 0;
    for (int i = 0; i < DIV+4; i++) begin
      @(negedge clk);
      if (!rdy_n) lows++;
    end
    chk("R7 no request", lows == 0, 1'b1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule